// File: doc/BRIEF.md
# Two-Cycle Flash Command Register

This block is the command register and mode sequencer of a 64K x 8 parallel flash device model. It watches an asynchronous-style bus (address, write data, active-low chip enable, output enable and write strobe) through a system clock. It also watches a flag that says the programming voltage is present. Bus writes are decoded as one-byte or two-byte commands only while that flag is high. The block then decides what a bus read returns: storage contents at the presented address, one of two signature bytes, or storage contents at an address it latched earlier for verification.

For program and erase it latches the operands and fires a one-clock start pulse. The program operands are the address taken when the strobe falls and the data taken when it rises. A matching active level stays high until the next write strobe ends, and that write strobe models the stop timer. The storage itself is outside the block. The block drives a storage address and receives the byte stored there on the same cycle.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset the block is in array-read mode, and reads return storage data at the bus address. progStart, eraseStart, progActive and eraseActive are all low.
- R2: A write whose strobe ends while hvOk is low changes no mode and no latch. While hvOk is low, every enabled read returns storage data at the bus address, whatever the mode.
- R3: Writing 00h selects array-read mode. Enabled reads then return storage data at the bus address.
- R4: Writing 90h selects signature mode. A read with address bit 0 clear returns 31h, and a read with address bit 0 set returns B8h.
- R5: Writing 20h twice in a row raises eraseStart for one clock. A 20h followed by any other byte starts no erase.
- R6: Writing 40h arms programming, and the next write is taken as the program byte whatever its value. progStart then pulses for one clock. progAddr shows the address present when that write's strobe fell, and progData shows the data present when it rose.
- R7: Writing A0h enters erase-verify. Reads then return storage data at the address present when that A0h write's strobe fell, ignoring the bus address.
- R8: Writing C0h enters program-verify. Reads then return storage data at progAddr, ignoring the bus address.
- R9: Two consecutive FFh writes return the block to array-read mode. A single FFh leaves the mode unchanged, except that it cancels a pending first 20h.
- R10: Any byte other than 00h, 20h, 40h, 90h, A0h, C0h or FFh returns the block to array-read mode and starts nothing.
- R11: progActive and eraseActive rise together with their start pulse. They stay high until the next write strobe ends, whether or not hvOk is high at that point.
- R12: busDoutEn is high only while ceN and oeN are low and weN is high. busDout is 00h whenever busDoutEn is low.
- R13: The start pulses, the active flags and the command mode all update on the first clock edge at which the strobe is seen released (ceN or weN high) after having been seen asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, returns to array-read mode |
| busAddr | input | 16 | Bus address |
| busDin | input | 8 | Bus write data |
| ceN | input | 1 | Active-low chip enable |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write strobe |
| hvOk | input | 1 | Programming voltage present |
| arrAddr | output | 16 | Address presented to the storage |
| arrRdata | input | 8 | Byte stored at arrAddr |
| busDout | output | 8 | Read data |
| busDoutEn | output | 1 | Read data is being driven |
| progStart | output | 1 | One-clock program start pulse |
| progAddr | output | 16 | Latched program address |
| progData | output | 8 | Latched program byte |
| eraseStart | output | 1 | One-clock erase start pulse |
| progActive | output | 1 | Program in progress |
| eraseActive | output | 1 | Erase in progress |

## Verification
Each write holds the strobe low across two rising clock edges and then releases it. The edge after the release is where the block sees the write end. That edge updates the mode, progAddr, progData, the start pulses and the active flags. The bench samples all of these at the falling edge that follows. It checks once more one clock later that each pulse has dropped while the active flag holds. Read data is combinational from the registered mode and latches, so reads are sampled one nanosecond after the inputs change, well before the next rising edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int BYTE_W = 8;

  // command codes
  localparam logic [BYTE_W-1:0] OP_READ   = 8'h00;
  localparam logic [BYTE_W-1:0] OP_SIGN   = 8'h90;
  localparam logic [BYTE_W-1:0] OP_ERASE  = 8'h20;
  localparam logic [BYTE_W-1:0] OP_PROG   = 8'h40;
  localparam logic [BYTE_W-1:0] OP_EVFY   = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_PVFY   = 8'hC0;
  localparam logic [BYTE_W-1:0] OP_ABORT  = 8'hFF;

  // signature bytes, selected by address bit 0
  localparam logic [BYTE_W-1:0] SIG_MAKER = 8'h31;
  localparam logic [BYTE_W-1:0] SIG_PART  = 8'hB8;

  typedef enum logic [2:0] {
    M_READ,
    M_SIGN,
    M_ERASE_ARM,
    M_ERASING,
    M_ERASE_VFY,
    M_PROG_ARM,
    M_PROGRAMMING,
    M_PROG_VFY
  } cmdMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capBusAddr;   // strobe fell: hold bus address
    logic capVfyAddr;   // erase-verify accepted: keep held address
    logic capProg;      // program byte accepted: keep address and data
  } dpStrobe_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              hvOk,
  input  logic [BYTE_W-1:0] busDin,
  output cmdMode_t          mode,
  output dpStrobe_t         strobe,
  output logic              progStart,
  output logic              eraseStart,
  output logic              progActive,
  output logic              eraseActive
);

  logic     wrSel, wrSelQ, fallEdge, riseEdge, accept;
  logic     ffSeen, ffNxt;
  logic     progGo, eraseGo, vfyGo;
  cmdMode_t modeNxt;

  assign wrSel    = !ceN && !weN;
  assign fallEdge = wrSel && !wrSelQ;
  assign riseEdge = !wrSel && wrSelQ;
  assign accept   = riseEdge && hvOk;

  always_comb begin
    modeNxt = mode;
    ffNxt   = ffSeen;
    progGo  = 1'b0;
    eraseGo = 1'b0;
    vfyGo   = 1'b0;
    if (accept) begin
      ffNxt = 1'b0;
      if (mode == M_PROG_ARM) begin
        progGo  = 1'b1;
        modeNxt = M_PROGRAMMING;
      end else begin
        case (busDin)
          OP_READ:  modeNxt = M_READ;
          OP_SIGN:  modeNxt = M_SIGN;
          OP_ERASE: begin
            if (mode == M_ERASE_ARM) begin
              eraseGo = 1'b1;
              modeNxt = M_ERASING;
            end else begin
              modeNxt = M_ERASE_ARM;
            end
          end
          OP_PROG:  modeNxt = M_PROG_ARM;
          OP_EVFY: begin
            vfyGo   = 1'b1;
            modeNxt = M_ERASE_VFY;
          end
          OP_PVFY:  modeNxt = M_PROG_VFY;
          OP_ABORT: begin
            if (ffSeen) begin
              modeNxt = M_READ;
            end else begin
              ffNxt = 1'b1;
              if (mode == M_ERASE_ARM) modeNxt = M_READ;
            end
          end
          default:  modeNxt = M_READ;
        endcase
      end
    end
  end

  always_comb begin
    strobe.capBusAddr = fallEdge;
    strobe.capVfyAddr = vfyGo;
    strobe.capProg    = progGo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSelQ      <= 1'b0;
      mode        <= M_READ;
      ffSeen      <= 1'b0;
      progStart   <= 1'b0;
      eraseStart  <= 1'b0;
      progActive  <= 1'b0;
      eraseActive <= 1'b0;
    end else begin
      wrSelQ     <= wrSel;
      mode       <= modeNxt;
      ffSeen     <= ffNxt;
      progStart  <= progGo;
      eraseStart <= eraseGo;
      if (riseEdge) begin
        progActive  <= progGo;
        eraseActive <= eraseGo;
      end
    end
  end

  // R2: a write ending without programming voltage leaves the mode alone
  a_r2_hv_gate: assert property (@(posedge clk) disable iff (!rstN)
    (riseEdge && !hvOk) |=> $stable(mode));

  // R5: erase pulse only after an armed erase
  a_r5_erase_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> ($past(mode) == M_ERASE_ARM));

  // R6: program pulse only after programming was armed
  a_r6_prog_needs_arm: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> ($past(mode) == M_PROG_ARM));

  // R10: at most one start pulse at a time
  a_r10_single_start: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStart, eraseStart}));

  // R11: active flags follow the start pulse of the same strobe end
  a_r11_active_follow: assert property (@(posedge clk) disable iff (!rstN)
    riseEdge |=> ((progActive == progStart) && (eraseActive == eraseStart)));

  // R13: start pulses last exactly one clock
  a_r13_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    (progStart || eraseStart) |=> !(progStart || eraseStart));

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  cmdMode_t          mode,
  input  logic              hvOk,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busDin,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [BYTE_W-1:0] arrRdata,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [BYTE_W-1:0] busDout,
  output logic              busDoutEn,
  output logic [ADDR_W-1:0] progAddr,
  output logic [BYTE_W-1:0] progData
);

  logic [ADDR_W-1:0] heldAddr, vfyAddr;
  logic [BYTE_W-1:0] readVal;
  logic              readEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      vfyAddr  <= '0;
      progAddr <= '0;
      progData <= '0;
    end else begin
      if (strobe.capBusAddr) heldAddr <= busAddr;
      if (strobe.capVfyAddr) vfyAddr  <= heldAddr;
      if (strobe.capProg) begin
        progAddr <= heldAddr;
        progData <= busDin;
      end
    end
  end

  assign readEn = !ceN && !oeN && weN;

  always_comb begin
    arrAddr = busAddr;
    readVal = arrRdata;
    if (hvOk) begin
      case (mode)
        M_SIGN:      readVal = busAddr[0] ? SIG_PART : SIG_MAKER;
        M_ERASE_VFY: arrAddr = vfyAddr;
        M_PROG_VFY:  arrAddr = progAddr;
        default:     arrAddr = busAddr;
      endcase
    end
  end

  assign busDoutEn = readEn;
  assign busDout   = readEn ? readVal : '0;

  // R6: program operands are the held address and the data at strobe end
  a_r6_prog_operands: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capProg |=> ((progData == $past(busDin)) && (progAddr == $past(heldAddr))));

  // R7: verify address is steady while erase-verify persists
  a_r7_vfy_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == M_ERASE_VFY) && ($past(mode) == M_ERASE_VFY)) |-> $stable(vfyAddr));

  // R8: program operands do not move outside a program capture
  a_r8_prog_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.capProg) |-> $stable(progAddr));

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busDin,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              hvOk,
  output logic [ADDR_W-1:0] arrAddr,
  input  logic [BYTE_W-1:0] arrRdata,
  output logic [BYTE_W-1:0] busDout,
  output logic              busDoutEn,
  output logic              progStart,
  output logic [ADDR_W-1:0] progAddr,
  output logic [BYTE_W-1:0] progData,
  output logic              eraseStart,
  output logic              progActive,
  output logic              eraseActive
);

  cmdMode_t   mode;
  dpStrobe_t  strobe;

  flash_cmd_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ceN         (ceN),
    .weN         (weN),
    .hvOk        (hvOk),
    .busDin      (busDin),
    .mode        (mode),
    .strobe      (strobe),
    .progStart   (progStart),
    .eraseStart  (eraseStart),
    .progActive  (progActive),
    .eraseActive (eraseActive)
  );

  flash_cmd_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .mode      (mode),
    .hvOk      (hvOk),
    .busAddr   (busAddr),
    .busDin    (busDin),
    .ceN       (ceN),
    .oeN       (oeN),
    .weN       (weN),
    .arrRdata  (arrRdata),
    .arrAddr   (arrAddr),
    .busDout   (busDout),
    .busDoutEn (busDoutEn),
    .progAddr  (progAddr),
    .progData  (progData)
  );

  // R12: nothing driven while a write strobe is low
  a_r12_no_drive_on_write: assert property (@(posedge clk) disable iff (!rstN)
    (!weN) |-> (!busDoutEn && (busDout == '0)));

endmodule

// File: tb/tb_flash_cmd_top.sv
module tb_flash_cmd_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = '0;
  logic [7:0]  busDin = '0;
  logic        ceN = 1'b1, oeN = 1'b1, weN = 1'b1, hvOk = 1'b1;
  logic [15:0] arrAddr;
  logic [7:0]  arrRdata;
  logic [7:0]  busDout;
  logic        busDoutEn;
  logic        progStart, eraseStart, progActive, eraseActive;
  logic [15:0] progAddr;
  logic [7:0]  progData;

  int nChk = 0;
  int nBad = 0;

  logic        sawProg, sawErase, sawPA, sawEA;
  logic [15:0] sawPAddr;
  logic [7:0]  sawPData;
  logic [7:0]  rd;
  logic        rdEn;

  always #2 clk = ~clk;

  function automatic logic [7:0] arrFn(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign arrRdata = arrFn(arrAddr);

  flash_cmd_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busDin(busDin),
    .ceN(ceN), .oeN(oeN), .weN(weN), .hvOk(hvOk),
    .arrAddr(arrAddr), .arrRdata(arrRdata), .busDout(busDout),
    .busDoutEn(busDoutEn), .progStart(progStart), .progAddr(progAddr),
    .progData(progData), .eraseStart(eraseStart),
    .progActive(progActive), .eraseActive(eraseActive)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] d, input logic [15:0] aFall,
                          input logic [15:0] aRise, input logic hv);
    @(negedge clk);
    hvOk = hv; ceN = 1'b0; oeN = 1'b1; busAddr = aFall; busDin = d; weN = 1'b0;
    @(negedge clk);
    busAddr = aRise;
    @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    sawProg = progStart; sawErase = eraseStart;
    sawPA = progActive; sawEA = eraseActive;
    sawPAddr = progAddr; sawPData = progData;
    ceN = 1'b1; hvOk = 1'b1;
  endtask

  task automatic cmd(input logic [7:0] d);
    busWrite(d, 16'h0000, 16'h0000, 1'b1);
  endtask

  task automatic busRead(input logic [15:0] a, input logic hv);
    @(negedge clk);
    hvOk = hv; ceN = 1'b0; oeN = 1'b0; weN = 1'b1; busAddr = a;
    #1;
    rd = busDout; rdEn = busDoutEn;
    oeN = 1'b1; ceN = 1'b1; hvOk = 1'b1;
  endtask

  // {command, read address, literal flag, literal value}
  localparam logic [32:0] VEC [8] = '{
    {8'h00, 16'h1234, 1'b0, 8'h00},   // R3
    {8'h90, 16'h0000, 1'b1, 8'h31},   // R4
    {8'h90, 16'h0001, 1'b1, 8'hB8},   // R4
    {8'h90, 16'h0F03, 1'b1, 8'hB8},   // R4 bit 0 set
    {8'h00, 16'hFFFF, 1'b0, 8'h00},   // R3
    {8'h90, 16'h0F02, 1'b1, 8'h31},   // R4 bit 0 clear
    {8'h55, 16'h0042, 1'b0, 8'h00},   // R10
    {8'h3F, 16'h8001, 1'b0, 8'h00}    // R10
  };

  initial begin : watchdog
    #(4 * 200000);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 progStart", progStart, 0);
    chk("R1 eraseStart", eraseStart, 0);
    chk("R1 progActive", progActive, 0);
    chk("R1 eraseActive", eraseActive, 0);
    busRead(16'h0010, 1'b1);
    chk("R1 read array", rd, arrFn(16'h0010));

    // table of commands and expected reads
    for (int i = 0; i < 8; i++) begin
      logic [32:0] v;
      logic [7:0]  expV;
      v = VEC[i];
      cmd(v[32:25]);
      chk("R10 no start pulse", {sawProg, sawErase}, 0);
      busRead(v[24:9], 1'b1);
      expV = v[8] ? v[7:0] : arrFn(v[24:9]);
      chk("R3/R4/R10 table read", rd, expV);
    end

    // R12 output enable
    @(negedge clk);
    ceN = 1'b0; oeN = 1'b1; weN = 1'b1; busAddr = 16'h0033;
    #1;
    chk("R12 disabled en", busDoutEn, 0);
    chk("R12 disabled data", busDout, 0);
    ceN = 1'b1;
    busRead(16'h0033, 1'b1);
    chk("R12 enabled en", rdEn, 1);

    // R5 double erase command, R11 / R13 flags
    cmd(8'h20);
    chk("R5 single 20h no erase", sawErase, 0);
    cmd(8'h20);
    chk("R13 erase pulse", sawErase, 1);
    chk("R11 erase active", sawEA, 1);
    @(negedge clk);
    chk("R13 erase pulse one clock", eraseStart, 0);
    chk("R11 erase active holds", eraseActive, 1);

    // R7 erase verify at address of the A0h write
    busWrite(8'hA0, 16'h0300, 16'h0777, 1'b1);
    chk("R11 erase active drops", sawEA, 0);
    busRead(16'h1111, 1'b1);
    chk("R7 verify read", rd, arrFn(16'h0300));

    // R5 negative: 20h then 00h
    cmd(8'h20);
    cmd(8'h00);
    chk("R5 20h then 00h no erase", sawErase, 0);
    busRead(16'h2222, 1'b1);
    chk("R5 back to read", rd, arrFn(16'h2222));

    // R6 program
    cmd(8'h40);
    chk("R6 arm no pulse", sawProg, 0);
    busWrite(8'h3C, 16'h4321, 16'h8765, 1'b1);
    chk("R6 prog pulse", sawProg, 1);
    chk("R6 prog addr", sawPAddr, 16'h4321);
    chk("R6 prog data", sawPData, 8'h3C);
    chk("R11 prog active", sawPA, 1);

    // R6 program byte of FFh is data, not abort
    cmd(8'h40);
    busWrite(8'hFF, 16'h0AA0, 16'h0000, 1'b1);
    chk("R6 FFh as data", sawPData, 8'hFF);
    chk("R6 FFh pulse", sawProg, 1);

    // R8 program verify
    cmd(8'hC0);
    chk("R11 prog active drops", sawPA, 0);
    busRead(16'h0005, 1'b1);
    chk("R8 verify read", rd, arrFn(16'h0AA0));

    // R2 writes ignored without programming voltage
    cmd(8'h90);
    busWrite(8'h00, 16'h0000, 16'h0000, 1'b0);
    busRead(16'h0000, 1'b1);
    chk("R2 ignored write", rd, 8'h31);
    busRead(16'h0000, 1'b0);
    chk("R2 read without voltage", rd, arrFn(16'h0000));

    // R9 single FFh keeps mode, second returns to read
    cmd(8'hFF);
    busRead(16'h0001, 1'b1);
    chk("R9 single FFh keeps mode", rd, 8'hB8);
    cmd(8'hFF);
    busRead(16'h0001, 1'b1);
    chk("R9 double FFh read mode", rd, arrFn(16'h0001));

    // R9 abort cancels armed erase
    cmd(8'h20);
    cmd(8'hFF);
    cmd(8'hFF);
    cmd(8'h20);
    chk("R9 no erase after abort", sawErase, 0);
    cmd(8'h00);
    busRead(16'h5A5A, 1'b1);
    chk("R9 read after abort", rd, arrFn(16'h5A5A));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule